// File: doc/BRIEF.md
# Fast Ethernet Transmit Line Encoder

This block turns the 4-bit transmit nibbles a MAC presents on its media-independent interface into the three-level symbol stream of a 100 Mb/s twisted-pair link. It runs entirely on the 125 MHz bit clock. A one-cycle strobe, raised once every five bit clocks, marks each new nibble together with its transmit-enable flag. Each nibble is mapped to a 5-bit code group, with frame delimiters inserted at the edges of a frame. The code group is shifted out one bit per clock and mixed with an 11-bit keystream generator. The result is converted to transition form (NRZI) and finally to a three-level (MLT3) symbol.

The output is a 2-bit code for an external line driver. `2'b01` means +1, `2'b11` means −1 and `2'b00` means 0. The NRZI level is also brought out for observation. Analog shaping and any 10 Mb/s path lie outside the block.

Top module: `fe_tx_encoder`

## Requirements
- R1: While `rst_n` is low the symbol output is `2'b00` (level 0).
- R2: A strobe taken while no frame is active and `tx_en` is low produces the idle code group `11111`.
- R3: A strobe with `tx_en` high while no frame is active produces `11000`. The very next strobe produces `11001`'s sibling `10001` whatever the inputs are. Together these two groups replace the first byte of the frame, and `txd` is ignored for both.
- R4: Inside a frame, a strobe with `tx_en` high maps `txd` as follows: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: The first strobe inside a frame with `tx_en` low produces `01101`. The next strobe produces `00111` whatever the inputs are. After that the encoder is back in the no-frame state, so a third strobe with `tx_en` high starts a new frame with `11000`.
- R6: Each code group is sent most significant bit first, one bit per clock. Strobes must be exactly five clocks apart.
- R7: The keystream comes from an 11-bit register `s` that is set to all ones by reset. On every clock after reset it shifts toward bit 10 and takes `s[10]^s[8]` into bit 0. That same value is XORed with the code bit of that clock, which gives a key sequence of period 2047.
- R8: A scrambled 1 toggles the NRZI level and moves the symbol one step along the cycle 0, +1, 0, −1. A scrambled 0 holds both. `2'b10` never appears.
- R9: Code bit k (k = 0 for the MSB) of a group loaded at strobe edge E determines the symbol present after edge E+k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nib_stb | input | 1 | One-cycle nibble strobe, every fifth clock |
| tx_en | input | 1 | Frame active flag, sampled with the strobe |
| txd | input | 4 | Transmit nibble, sampled with the strobe |
| line_nrzi | output | 1 | Current NRZI level |
| line_sym | output | 2 | MLT3 symbol: 00 = 0, 01 = +1, 11 = −1 |

## Verification
The code bit loaded at strobe edge E with index k first affects the symbol after edge E+k+2. There is one register stage in the scrambler and one in the line coder. The monitor samples the symbol on falling edges. It delays both the strobe flag and its own model of the keystream by two clocks, so every recovered bit lines up with the key that was applied to it. A symbol change is read as a scrambled 1 and XORed with that key. Each five-bit group rebuilt this way is compared against the code the driver queued when it raised the strobe.

// File: rtl/fe_tx_pkg.sv
package fe_tx_pkg;

    localparam int CODE_W = 5;
    localparam int NIB_W  = 4;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_SSD2 = 2'd1,
        FR_DATA = 2'd2,
        FR_ESD2 = 2'd3
    } frame_st_e;

    localparam code_t C_IDLE = 5'b11111;
    localparam code_t C_J    = 5'b11000;
    localparam code_t C_K    = 5'b10001;
    localparam code_t C_T    = 5'b01101;
    localparam code_t C_R    = 5'b00111;

    localparam logic [1:0] SYM_ZERO = 2'b00;
    localparam logic [1:0] SYM_POS  = 2'b01;
    localparam logic [1:0] SYM_NEG  = 2'b11;

    function automatic code_t data_code(input logic [NIB_W-1:0] nib);
        code_t c;
        case (nib)
            4'h0: c = 5'b11110;
            4'h1: c = 5'b01001;
            4'h2: c = 5'b10100;
            4'h3: c = 5'b10101;
            4'h4: c = 5'b01010;
            4'h5: c = 5'b01011;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b10010;
            4'h9: c = 5'b10011;
            4'hA: c = 5'b10110;
            4'hB: c = 5'b10111;
            4'hC: c = 5'b11010;
            4'hD: c = 5'b11011;
            4'hE: c = 5'b11100;
            default: c = 5'b11101;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fe_tx_coder.sv
// Framing state machine, nibble-to-code mapping and MSB-first serializer.
module fe_tx_coder
    import fe_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nib_stb,
    input  logic             tx_en,
    input  logic [NIB_W-1:0] txd,
    output logic             ser_bit
);

    typedef struct packed {
        frame_st_e st;
        code_t     sh;
    } coder_s;

    coder_s q, d;

    always_comb begin
        d = q;
        if (nib_stb) begin
            case (q.st)
                FR_IDLE: begin
                    if (tx_en) begin
                        d.sh = C_J;       // R3 first delimiter half
                        d.st = FR_SSD2;
                    end else begin
                        d.sh = C_IDLE;    // R2
                    end
                end
                FR_SSD2: begin
                    d.sh = C_K;           // R3 second half, inputs ignored
                    d.st = FR_DATA;
                end
                FR_DATA: begin
                    if (tx_en) begin
                        d.sh = data_code(txd);  // R4
                    end else begin
                        d.sh = C_T;       // R5
                        d.st = FR_ESD2;
                    end
                end
                default: begin
                    d.sh = C_R;           // R5, inputs ignored
                    d.st = FR_IDLE;
                end
            endcase
        end else begin
            d.sh = {q.sh[CODE_W-2:0], 1'b1};  // R6 shift toward MSB
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: FR_IDLE, sh: C_IDLE};
        end else begin
            q <= d;
        end
    end

    assign ser_bit = q.sh[CODE_W-1];

endmodule

// File: rtl/fe_tx_scrambler.sv
// Side-stream keystream generator; one registered stage.
module fe_tx_scrambler #(
    parameter int LFSR_W = 11,
    parameter int TAP_A  = 10,
    parameter int TAP_B  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic bit_out
);

    localparam logic [LFSR_W-1:0] SEED = {LFSR_W{1'b1}};

    typedef struct packed {
        logic [LFSR_W-1:0] s;
        logic              o;
    } scr_s;

    scr_s q, d;
    logic key;

    always_comb begin
        key   = q.s[TAP_A] ^ q.s[TAP_B];
        d.s   = {q.s[LFSR_W-2:0], key};   // R7
        d.o   = bit_in ^ key;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{s: SEED, o: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign bit_out = q.o;

endmodule

// File: rtl/fe_tx_line.sv
// NRZI conversion followed by the three-level symbol coder.
module fe_tx_line
    import fe_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scr_bit,
    output logic       nrzi,
    output logic [1:0] sym
);

    typedef struct packed {
        logic       lvl;
        logic [1:0] phase;
    } line_s;

    line_s q, d;

    always_comb begin
        d     = q;
        d.lvl = q.lvl ^ scr_bit;          // R8 toggle on 1
        if (d.lvl != q.lvl) begin
            d.phase = q.phase + 2'd1;     // R8 step on every transition
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{lvl: 1'b0, phase: 2'd0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (q.phase)
            2'd1:    sym = SYM_POS;
            2'd3:    sym = SYM_NEG;
            default: sym = SYM_ZERO;
        endcase
    end

    assign nrzi = q.lvl;

endmodule

// File: rtl/fe_tx_encoder.sv
module fe_tx_encoder #(
    parameter int LFSR_W = 11,
    parameter int TAP_A  = 10,
    parameter int TAP_B  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nib_stb,
    input  logic       tx_en,
    input  logic [3:0] txd,
    output logic       line_nrzi,
    output logic [1:0] line_sym
);

    logic ser_bit;
    logic scr_bit;

    fe_tx_coder u_coder (
        .clk     (clk),
        .rst_n   (rst_n),
        .nib_stb (nib_stb),
        .tx_en   (tx_en),
        .txd     (txd),
        .ser_bit (ser_bit)
    );

    fe_tx_scrambler #(
        .LFSR_W (LFSR_W),
        .TAP_A  (TAP_A),
        .TAP_B  (TAP_B)
    ) u_scr (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (ser_bit),
        .bit_out (scr_bit)
    );

    fe_tx_line u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .scr_bit (scr_bit),
        .nrzi    (line_nrzi),
        .sym     (line_sym)
    );

endmodule

// File: rtl/fe_tx_checks.sv
module fe_tx_checks #(
    parameter int GRP = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       nib_stb,
    input logic [1:0] line_sym
);

    logic [7:0] gap_q;
    logic       stb_seen_q;
    logic       nz_seen_q;
    logic       last_neg_q;
    logic [1:0] sym_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q      <= '0;
            stb_seen_q <= 1'b0;
            nz_seen_q  <= 1'b0;
            last_neg_q <= 1'b0;
            sym_prev_q <= 2'b00;
        end else begin
            if (nib_stb) begin
                gap_q      <= '0;
                stb_seen_q <= 1'b1;
            end else if (gap_q != 8'hFF) begin
                gap_q <= gap_q + 8'd1;
            end
            sym_prev_q <= line_sym;
            if (line_sym != 2'b00) begin
                nz_seen_q  <= 1'b1;
                last_neg_q <= line_sym[1];
            end
        end
    end

    // R8
    sym_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_sym != 2'b10);

    // R8
    no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_prev_q != 2'b00) |-> (line_sym == sym_prev_q || line_sym == 2'b00));

    // R8
    alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_prev_q == 2'b00 && line_sym != 2'b00 && nz_seen_q)
            |-> (line_sym[1] != last_neg_q));

    // R6
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_stb && stb_seen_q) |-> (gap_q == 8'(GRP - 1)));

endmodule

bind fe_tx_encoder fe_tx_checks #(.GRP(fe_tx_pkg::CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .nib_stb  (nib_stb),
    .line_sym (line_sym)
);

// File: tb/tb_fe_tx_encoder.sv
module tb_fe_tx_encoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nib_stb = 1'b0;
    logic       tx_en = 1'b0;
    logic [3:0] txd = 4'h0;
    logic       line_nrzi;
    logic [1:0] line_sym;

    int checks = 0;
    int errors = 0;

    logic [4:0] exp_q[$];
    string      tag_q[$];
    int         tb_st = 0;

    logic [10:0] lfsr_tb;
    logic [2:0]  stbh;
    logic [2:0]  kh;
    logic [1:0]  sym_prev;
    logic [4:0]  acc;
    int          cnt = 0;
    bit          coll = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    fe_tx_encoder dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .nib_stb   (nib_stb),
        .tx_en     (tx_en),
        .txd       (txd),
        .line_nrzi (line_nrzi),
        .line_sym  (line_sym)
    );

    function automatic logic [4:0] tb_map(input logic [3:0] n);
        case (n)
            4'h0: return 5'b11110;  4'h1: return 5'b01001;
            4'h2: return 5'b10100;  4'h3: return 5'b10101;
            4'h4: return 5'b01010;  4'h5: return 5'b01011;
            4'h6: return 5'b01110;  4'h7: return 5'b01111;
            4'h8: return 5'b10010;  4'h9: return 5'b10011;
            4'hA: return 5'b10110;  4'hB: return 5'b10111;
            4'hC: return 5'b11010;  4'hD: return 5'b11011;
            4'hE: return 5'b11100;  default: return 5'b11101;
        endcase
    endfunction

    // R7 keystream model: seed all ones, feedback s[10]^s[8] into bit 0
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_tb <= 11'h7FF;
            stbh    <= 3'b000;
        end else begin
            lfsr_tb <= {lfsr_tb[9:0], lfsr_tb[10] ^ lfsr_tb[8]};
            stbh    <= {stbh[1:0], nib_stb};
        end
    end

    // Monitor: recovers each code group from symbol changes (R6 R7 R8 R9)
    always @(negedge clk) begin
        logic bitv;
        if (!rst_n) begin
            kh       = 3'b000;
            coll     = 0;
            sym_prev = line_sym;
        end else begin
            kh       = {kh[1:0], lfsr_tb[10] ^ lfsr_tb[8]};
            bitv     = (line_sym != sym_prev) ^ kh[2];
            sym_prev = line_sym;
            if (stbh[2]) begin
                acc  = {4'b0000, bitv};
                cnt  = 1;
                coll = 1;
            end else if (coll) begin
                acc = {acc[3:0], bitv};
                cnt = cnt + 1;
            end
            if (coll && cnt == 5) begin
                coll = 0;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R9 unexpected group actual=%b expected=none", acc);
                end else begin
                    logic [4:0] e;
                    string      t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (acc !== e) begin
                        errors++;
                        $display("FAIL %s (R6 R7 R8 R9) group actual=%b expected=%b", t, acc, e);
                    end
                end
            end
        end
    end

    // Driver: one strobe every five clocks; pushes the expected group
    task automatic send(input bit en, input logic [3:0] d);
        logic [4:0] e;
        string      t;
        @(negedge clk);
        case (tb_st)
            0: if (en) begin e = 5'b11000; t = "R3"; tb_st = 1; end
               else    begin e = 5'b11111; t = "R2"; end
            1: begin e = 5'b10001; t = "R3"; tb_st = 2; end
            2: if (en) begin e = tb_map(d); t = "R4"; end
               else    begin e = 5'b01101; t = "R5"; tb_st = 3; end
            default: begin e = 5'b00111; t = "R5"; tb_st = 0; end
        endcase
        exp_q.push_back(e);
        tag_q.push_back(t);
        nib_stb = 1'b1;
        tx_en   = en;
        txd     = d;
        @(negedge clk);
        nib_stb = 1'b0;
        txd     = ~d;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset level
        repeat (3) begin
            @(negedge clk);
            checks++;
            if (line_sym !== 2'b00) begin
                errors++;
                $display("FAIL R1 reset sym actual=%b expected=00", line_sym);
            end
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        repeat (6) send(1'b0, 4'h3);                 // R2 idle
        // Frame A: preamble nibbles, start marker, all 16 values
        repeat (14) send(1'b1, 4'h5);                 // R3 first two replaced
        send(1'b1, 4'hD);
        for (int i = 0; i < 16; i++) send(1'b1, 4'(i));  // R4
        send(1'b0, 4'h0);                             // R5 T
        send(1'b0, 4'h0);                             // R5 R
        repeat (3) send(1'b0, 4'hA);
        // Frame B: restart right after the end delimiter
        repeat (4) send(1'b1, 4'h7);
        send(1'b0, 4'h9);                             // R5 T
        send(1'b1, 4'h6);                             // R5 R, tx_en ignored
        send(1'b1, 4'h6);                             // R3 J
        send(1'b1, 4'h6);                             // R3 K
        send(1'b1, 4'h3);
        send(1'b1, 4'h9);
        send(1'b0, 4'h0);
        send(1'b0, 4'h0);
        // Frame C: tx_en drops immediately after the start
        send(1'b1, 4'hF);                             // R3 J
        send(1'b0, 4'hF);                             // R3 K despite tx_en low
        send(1'b0, 4'h2);                             // R5 T
        send(1'b0, 4'h2);                             // R5 R
        // Long idle run covers a full keystream period (R7)
        repeat (450) send(1'b0, 4'h1);
        repeat (12) @(negedge clk);

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9 groups never emitted actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule